// File: doc/BRIEF.md
# Branch, Call and Return Sequencer

This block resolves control flow for a simple in-order processor. Each accepted instruction names one of six control operations: a PC-relative jump that depends on a flag word, an unconditional PC-relative jump, a call or branch through a register target, a call with a PC-relative target, and a return. The block computes the next PC. For saving operations it also issues a stack memory write that stores the link address. When the stack register changes, it issues a register write-back of the new stack pointer.

The stack grows upward and is addressed through an ordinary general register. A push stores the link address at the current stack pointer and then raises the pointer by the register size in bytes. A return reads memory at the current pointer, takes the next PC from the returned data and then lowers the pointer. The jump conditions come from a flag word held in a general register, which the decode stage passes in on `flags_i`. A return is split across two phases: a one-cycle read request, then completion once read data arrives. While the return is pending, `busy_o` is high and the block accepts no new instruction.

Top module: `flow_seq`

## Requirements
- R1: While `rst_ni` is low, and in the first cycle after reset with no instruction offered, `pc_valid_o`, `mem_we_o`, `mem_re_o`, `rf_we_o` and `busy_o` are all low.
- R2: `op_i`=1 is a conditional jump. The `cond_i` codes and the flag bits they test are: 0 carry (bit 0), 1 borrow (bit 1), 2 overflow (bit 2), 3 greater (bit 3), 4 greater or equal (bit 3 OR bit 4), 5 equal (bit 4), 6 not equal (bit 4 clear), 7 less or equal (bit 5 OR bit 4), 8 less (bit 5), 9 the whole flag word is zero, 10 the whole flag word is non-zero. When the condition holds, the next cycle shows `pc_valid_o`=1 and `next_pc_o` = `pc_i` + sign-extended `imm_i`.
- R3: A conditional jump whose condition is false, or whose `cond_i` is 11 to 15, gives `next_pc_o` = `pc_i` + 4 with no memory or register write.
- R4: `op_i`=2 always gives `next_pc_o` = `pc_i` + sign-extended `imm_i` in the next cycle.
- R5: `op_i`=3 (register call) produces three results in the next cycle: a memory write of `pc_i`+4 at address `sp_i`; a register write of `sp_i`+4 to index `sp_idx_i`; and `next_pc_o` = `tgt_i`.
- R6: `op_i`=4 (register branch) writes `pc_i`+4 to memory at `sp_i` and gives `next_pc_o` = `tgt_i`, with no register write.
- R7: `op_i`=6 (immediate call) pushes and increments exactly as in R5, but gives `next_pc_o` = `pc_i` + sign-extended `imm_i`.
- R8: `op_i`=5 (return) raises `mem_re_o` for exactly one cycle, in the cycle after issue, with `mem_addr_o` = `sp_i` as sampled at issue. `busy_o` is then high, and `pc_valid_o` stays low until read data arrives.
- R9: The cycle after `rdata_valid_i` is seen with `busy_o` high, the block shows `pc_valid_o`=1 with `next_pc_o` = `rdata_i`, and writes the issue-time `sp_i`-4 back to the issue-time `sp_idx_i`. `busy_o` falls in that same cycle.
- R10: While `busy_o` is high, `valid_i` is ignored, including in the cycle where `rdata_valid_i` arrives.
- R11: With `valid_i` low, or with `op_i`=0, no output strobe is raised. `rdata_valid_i` outside a pending return has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Instruction offered this cycle |
| op_i | input | 3 | Control operation code |
| cond_i | input | 4 | Condition code for the conditional jump |
| imm_i | input | IMM_W | Signed PC-relative offset |
| pc_i | input | XLEN | Address of the current instruction |
| flags_i | input | XLEN | Value of the condition register |
| tgt_i | input | XLEN | Value of the target register |
| sp_i | input | XLEN | Value of the stack register |
| sp_idx_i | input | RIDX_W | Index of the stack register |
| rdata_valid_i | input | 1 | Memory read data valid |
| rdata_i | input | XLEN | Memory read data |
| pc_valid_o | output | 1 | Next PC valid |
| next_pc_o | output | XLEN | Resolved next PC |
| mem_we_o | output | 1 | Stack memory write request |
| mem_re_o | output | 1 | Stack memory read request |
| mem_addr_o | output | XLEN | Stack memory address |
| mem_wdata_o | output | XLEN | Link address to store |
| rf_we_o | output | 1 | Stack pointer write-back strobe |
| rf_idx_o | output | RIDX_W | Write-back register index |
| rf_wdata_o | output | XLEN | Updated stack pointer |
| busy_o | output | 1 | Return pending; input not accepted |

## Verification
Completion of a pending return and the offer of a new instruction can fall in the same cycle. The bench provokes this by holding `valid_i` high with a jump on the exact cycle that read data returns. It then expects the next cycle to show only the return's PC and stack pointer write-back, and the cycle after that to be quiet. A second overlap is the push in a call, where the memory write, the pointer write-back and the redirect all appear together. In that case the bench checks that the write-back value is exactly one register size above the write address.

// File: rtl/flow_seq_pkg.sv
package flow_seq_pkg;
  typedef enum logic [2:0] {
    FOP_NONE  = 3'd0,
    FOP_JCC   = 3'd1,
    FOP_JMP   = 3'd2,
    FOP_CALLR = 3'd3,
    FOP_BRR   = 3'd4,
    FOP_RET   = 3'd5,
    FOP_CALLI = 3'd6
  } flow_op_e;

  localparam int unsigned FLG_CARRY  = 0;
  localparam int unsigned FLG_BORROW = 1;
  localparam int unsigned FLG_OVF    = 2;
  localparam int unsigned FLG_GT     = 3;
  localparam int unsigned FLG_EQ     = 4;
  localparam int unsigned FLG_LT     = 5;
  localparam int unsigned NUM_CC     = 11;

  typedef enum logic [1:0] {
    RS_IDLE = 2'd0,
    RS_REQ  = 2'd1,
    RS_WAIT = 2'd2
  } ret_state_e;
endpackage

// File: rtl/flow_cond_eval.sv
module flow_cond_eval
  import flow_seq_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [3:0]      cond_i,
  input  logic [XLEN-1:0] flags_i,
  output logic            take_o
);
  logic [15:0] cc_vec;
  logic        f_gt, f_eq, f_lt, f_zero;

  assign f_gt   = flags_i[FLG_GT];
  assign f_eq   = flags_i[FLG_EQ];
  assign f_lt   = flags_i[FLG_LT];
  assign f_zero = (flags_i == '0);

  always_comb begin
    cc_vec     = '0;
    cc_vec[0]  = flags_i[FLG_CARRY];
    cc_vec[1]  = flags_i[FLG_BORROW];
    cc_vec[2]  = flags_i[FLG_OVF];
    cc_vec[3]  = f_gt;
    cc_vec[4]  = f_gt | f_eq;
    cc_vec[5]  = f_eq;
    cc_vec[6]  = ~f_eq;
    cc_vec[7]  = f_lt | f_eq;
    cc_vec[8]  = f_lt;
    cc_vec[9]  = f_zero;
    cc_vec[10] = ~f_zero;
    // codes NUM_CC..15 stay clear: reserved, never taken
  end

  assign take_o = cc_vec[cond_i];
endmodule

// File: rtl/flow_addr_calc.sv
module flow_addr_calc #(
  parameter int unsigned XLEN       = 32,
  parameter int unsigned IMM_W      = 16,
  parameter int unsigned INSN_BYTES = 4,
  parameter int unsigned REG_BYTES  = XLEN / 8
) (
  input  logic [XLEN-1:0]  pc_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic [XLEN-1:0]  sp_i,
  output logic [XLEN-1:0]  rel_tgt_o,
  output logic [XLEN-1:0]  link_o,
  output logic [XLEN-1:0]  sp_up_o,
  output logic [XLEN-1:0]  sp_dn_o
);
  localparam logic [XLEN-1:0] INSN_STEP = XLEN'(INSN_BYTES);
  localparam logic [XLEN-1:0] SP_STEP   = XLEN'(REG_BYTES);

  logic [XLEN-1:0] imm_ext;

  generate
    if (IMM_W >= XLEN) begin : g_trunc
      assign imm_ext = imm_i[XLEN-1:0];
    end else begin : g_sext
      assign imm_ext = {{(XLEN-IMM_W){imm_i[IMM_W-1]}}, imm_i};
    end
  endgenerate

  assign rel_tgt_o = pc_i + imm_ext;
  assign link_o    = pc_i + INSN_STEP;
  assign sp_up_o   = sp_i + SP_STEP;
  assign sp_dn_o   = sp_i - SP_STEP;
endmodule

// File: rtl/flow_ret_ctrl.sv
module flow_ret_ctrl
  import flow_seq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic rdata_valid_i,
  output logic req_o,
  output logic busy_o,
  output logic accept_o
);
  ret_state_e state_q, state_d;

  assign req_o    = (state_q == RS_REQ);
  assign busy_o   = (state_q != RS_IDLE);
  assign accept_o = busy_o & rdata_valid_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      RS_IDLE: if (start_i) state_d = RS_REQ;
      RS_REQ:  state_d = rdata_valid_i ? RS_IDLE : RS_WAIT;
      RS_WAIT: if (rdata_valid_i) state_d = RS_IDLE;
      default: state_d = RS_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= RS_IDLE;
    else         state_q <= state_d;
  end
endmodule

// File: rtl/flow_seq.sv
module flow_seq
  import flow_seq_pkg::*;
#(
  parameter int unsigned XLEN       = 32,
  parameter int unsigned IMM_W      = 16,
  parameter int unsigned RIDX_W     = 4,
  parameter int unsigned INSN_BYTES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [2:0]        op_i,
  input  logic [3:0]        cond_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic [XLEN-1:0]   pc_i,
  input  logic [XLEN-1:0]   flags_i,
  input  logic [XLEN-1:0]   tgt_i,
  input  logic [XLEN-1:0]   sp_i,
  input  logic [RIDX_W-1:0] sp_idx_i,
  input  logic              rdata_valid_i,
  input  logic [XLEN-1:0]   rdata_i,
  output logic              pc_valid_o,
  output logic [XLEN-1:0]   next_pc_o,
  output logic              mem_we_o,
  output logic              mem_re_o,
  output logic [XLEN-1:0]   mem_addr_o,
  output logic [XLEN-1:0]   mem_wdata_o,
  output logic              rf_we_o,
  output logic [RIDX_W-1:0] rf_idx_o,
  output logic [XLEN-1:0]   rf_wdata_o,
  output logic              busy_o
);
  localparam int unsigned REG_BYTES = XLEN / 8;

  flow_op_e        op;
  logic            take, busy, ret_req, ret_accept, issue;
  logic [XLEN-1:0] rel_tgt, link, sp_up, sp_dn;

  logic              pc_valid_q, mem_we_q, rf_we_q;
  logic [XLEN-1:0]   next_pc_q, mem_addr_q, mem_wdata_q, rf_wdata_q;
  logic [RIDX_W-1:0] rf_idx_q;
  logic [XLEN-1:0]   ret_sp_dn_q;
  logic [RIDX_W-1:0] ret_idx_q;

  assign op    = flow_op_e'(op_i);
  assign issue = valid_i & ~busy;

  flow_cond_eval #(.XLEN(XLEN)) u_cond (
    .cond_i (cond_i),
    .flags_i(flags_i),
    .take_o (take)
  );

  flow_addr_calc #(
    .XLEN(XLEN), .IMM_W(IMM_W), .INSN_BYTES(INSN_BYTES), .REG_BYTES(REG_BYTES)
  ) u_addr (
    .pc_i     (pc_i),
    .imm_i    (imm_i),
    .sp_i     (sp_i),
    .rel_tgt_o(rel_tgt),
    .link_o   (link),
    .sp_up_o  (sp_up),
    .sp_dn_o  (sp_dn)
  );

  flow_ret_ctrl u_ret (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (issue && op == FOP_RET),
    .rdata_valid_i(rdata_valid_i),
    .req_o        (ret_req),
    .busy_o       (busy),
    .accept_o     (ret_accept)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_valid_q  <= 1'b0;
      mem_we_q    <= 1'b0;
      rf_we_q     <= 1'b0;
      next_pc_q   <= '0;
      mem_addr_q  <= '0;
      mem_wdata_q <= '0;
      rf_wdata_q  <= '0;
      rf_idx_q    <= '0;
      ret_sp_dn_q <= '0;
      ret_idx_q   <= '0;
    end else begin
      pc_valid_q <= 1'b0;
      mem_we_q   <= 1'b0;
      rf_we_q    <= 1'b0;
      if (ret_accept) begin
        pc_valid_q <= 1'b1;
        next_pc_q  <= rdata_i;
        rf_we_q    <= 1'b1;
        rf_idx_q   <= ret_idx_q;
        rf_wdata_q <= ret_sp_dn_q;
      end else if (issue) begin
        unique case (op)
          FOP_JCC: begin
            pc_valid_q <= 1'b1;
            next_pc_q  <= take ? rel_tgt : link;
          end
          FOP_JMP: begin
            pc_valid_q <= 1'b1;
            next_pc_q  <= rel_tgt;
          end
          FOP_CALLR, FOP_BRR, FOP_CALLI: begin
            pc_valid_q  <= 1'b1;
            next_pc_q   <= (op == FOP_CALLI) ? rel_tgt : tgt_i;
            mem_we_q    <= 1'b1;
            mem_addr_q  <= sp_i;
            mem_wdata_q <= link;
            if (op != FOP_BRR) begin
              rf_we_q    <= 1'b1;
              rf_idx_q   <= sp_idx_i;
              rf_wdata_q <= sp_up;
            end
          end
          FOP_RET: begin
            mem_addr_q  <= sp_i;
            ret_sp_dn_q <= sp_dn;
            ret_idx_q   <= sp_idx_i;
          end
          default: ;
        endcase
      end
    end
  end

  assign pc_valid_o  = pc_valid_q;
  assign next_pc_o   = next_pc_q;
  assign mem_we_o    = mem_we_q;
  assign mem_re_o    = ret_req;
  assign mem_addr_o  = mem_addr_q;
  assign mem_wdata_o = mem_wdata_q;
  assign rf_we_o     = rf_we_q;
  assign rf_idx_o    = rf_idx_q;
  assign rf_wdata_o  = rf_wdata_q;
  assign busy_o      = busy;
endmodule

// File: rtl/flow_seq_chk.sv
module flow_seq_chk #(
  parameter int unsigned XLEN = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            rdata_valid_i,
  input logic            pc_valid_o,
  input logic            mem_we_o,
  input logic            mem_re_o,
  input logic [XLEN-1:0] mem_addr_o,
  input logic            rf_we_o,
  input logic [XLEN-1:0] rf_wdata_o,
  input logic            busy_o
);
  localparam logic [XLEN-1:0] SP_STEP = XLEN'(XLEN / 8);

  p_push_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o && rf_we_o |-> rf_wdata_o == mem_addr_o + SP_STEP);

  p_write_redirects_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> pc_valid_o && !mem_re_o);

  p_read_stalls_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_re_o |-> busy_o && !pc_valid_o && !mem_we_o);

  p_req_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_re_o |=> !mem_re_o);

  p_ret_finish_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> pc_valid_o && rf_we_o && !mem_we_o);

  p_busy_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !rdata_valid_i |=> busy_o && !pc_valid_o && !mem_we_o && !rf_we_o);
endmodule

bind flow_seq flow_seq_chk #(.XLEN(XLEN)) u_flow_seq_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .rdata_valid_i(rdata_valid_i),
  .pc_valid_o   (pc_valid_o),
  .mem_we_o     (mem_we_o),
  .mem_re_o     (mem_re_o),
  .mem_addr_o   (mem_addr_o),
  .rf_we_o      (rf_we_o),
  .rf_wdata_o   (rf_wdata_o),
  .busy_o       (busy_o)
);

// File: tb/flow_seq_tb_top.sv
module flow_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid, rv;
  logic [2:0]  op;
  logic [3:0]  cc, idx;
  logic [15:0] imm;
  logic [31:0] pc, flags, tgt, sp, rd;
  logic        pcv_o, we_o, re_o, rfw_o, busy_o;
  logic [31:0] npc_o, addr_o, wd_o, rfd_o;
  logic [3:0]  rfi_o;

  int errors = 0;
  int checks = 0;
  bit ended  = 1'b0;

  typedef struct {
    bit pcv; logic [31:0] npc;
    bit we;  bit re; logic [31:0] addr; logic [31:0] wd;
    bit rfw; logic [3:0] rfi; logic [31:0] rfd;
    bit busy; string tag;
  } exp_t;

  exp_t q[$];

  always #10 clk = ~clk;

  flow_seq dut_i (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .op_i(op), .cond_i(cc),
    .imm_i(imm), .pc_i(pc), .flags_i(flags), .tgt_i(tgt), .sp_i(sp),
    .sp_idx_i(idx), .rdata_valid_i(rv), .rdata_i(rd),
    .pc_valid_o(pcv_o), .next_pc_o(npc_o), .mem_we_o(we_o), .mem_re_o(re_o),
    .mem_addr_o(addr_o), .mem_wdata_o(wd_o), .rf_we_o(rfw_o), .rf_idx_o(rfi_o),
    .rf_wdata_o(rfd_o), .busy_o(busy_o)
  );

  function automatic exp_t quiet(string tag);
    exp_t e;
    e = '{pcv:0, npc:0, we:0, re:0, addr:0, wd:0, rfw:0, rfi:0, rfd:0, busy:0, tag:tag};
    return e;
  endfunction

  function automatic logic [31:0] sx(logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction

  function automatic bit want_take(logic [3:0] c, logic [31:0] f);
    case (c)
      4'd0:  return f[0];
      4'd1:  return f[1];
      4'd2:  return f[2];
      4'd3:  return f[3];
      4'd4:  return f[3] || f[4];
      4'd5:  return f[4];
      4'd6:  return !f[4];
      4'd7:  return f[5] || f[4];
      4'd8:  return f[5];
      4'd9:  return f == 0;
      4'd10: return f != 0;
      default: return 1'b0;
    endcase
  endfunction

  task automatic drive(bit v, logic [2:0] o, logic [3:0] c, logic [15:0] im,
                       logic [31:0] p, logic [31:0] fl, logic [31:0] t,
                       logic [31:0] s, logic [3:0] ix, bit r, logic [31:0] d,
                       exp_t e);
    @(negedge clk);
    valid = v; op = o; cc = c; imm = im; pc = p; flags = fl; tgt = t;
    sp = s; idx = ix; rv = r; rd = d;
    q.push_back(e);
  endtask

  task automatic idle(string tag);
    drive(0, 3'd0, 0, 0, 0, 0, 0, 0, 0, 0, 0, quiet(tag));
  endtask

  // monitor: compares outputs 5 ns after each edge
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (q.size() > 0) begin
        exp_t e;
        bit ok;
        e = q.pop_front();
        ok = (pcv_o == e.pcv) && (!e.pcv || npc_o == e.npc) &&
             (we_o == e.we) && (re_o == e.re) &&
             (!(e.we || e.re) || addr_o == e.addr) && (!e.we || wd_o == e.wd) &&
             (rfw_o == e.rfw) && (!e.rfw || (rfi_o == e.rfi && rfd_o == e.rfd)) &&
             (busy_o == e.busy);
        checks++;
        if (!ok) begin
          errors++;
          $display("FAIL %s: got pcv=%0b npc=%h we=%0b re=%0b addr=%h wd=%h rfw=%0b rfi=%0d rfd=%h busy=%0b exp pcv=%0b npc=%h we=%0b re=%0b addr=%h wd=%h rfw=%0b rfi=%0d rfd=%h busy=%0b",
                   e.tag, pcv_o, npc_o, we_o, re_o, addr_o, wd_o, rfw_o, rfi_o, rfd_o, busy_o,
                   e.pcv, e.npc, e.we, e.re, e.addr, e.wd, e.rfw, e.rfi, e.rfd, e.busy);
        end
      end
    end
  end

  initial begin
    #(20 * 200000);
    if (!ended) begin
      ended = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    exp_t e;
    logic [31:0] pats [4];
    valid = 0; op = 0; cc = 0; imm = 0; pc = 0; flags = 0; tgt = 0;
    sp = 0; idx = 0; rv = 0; rd = 0;
    pats[0] = 32'h0; pats[1] = 32'h10; pats[2] = 32'h8000_0000; pats[3] = 32'h0;
    repeat (3) @(negedge clk);
    // R1 during reset
    checks++;
    if (pcv_o || we_o || re_o || rfw_o || busy_o) begin
      errors++;
      $display("FAIL R1: got strobes %b%b%b%b%b exp 00000", pcv_o, we_o, re_o, rfw_o, busy_o);
    end
    rst_n = 1'b1;
    idle("R1 after reset");

    // R2/R3: flag word that makes each code true, then fixed patterns
    for (int c = 0; c <= 10; c++) begin
      logic [31:0] f;
      f = (c == 4 || c == 5) ? 32'h10 : (c == 7 || c == 8) ? 32'h20 :
          (c == 9) ? 32'h0 : (c == 10) ? 32'h1 : (c == 6) ? 32'h8 : (32'h1 << c);
      e = quiet("R2 taken");
      e.pcv = 1; e.npc = 32'h1000 + sx(16'hFFF0);
      drive(1, 3'd1, 4'(c), 16'hFFF0, 32'h1000, f, 0, 0, 0, 0, 0, e);
    end
    for (int p = 1; p < 3; p++) begin
      for (int c = 0; c <= 10; c++) begin
        bit t;
        t = want_take(4'(c), pats[p]);
        e = quiet(t ? "R2 pattern taken" : "R3 pattern not taken");
        e.pcv = 1; e.npc = t ? 32'h2000 + 32'h40 : 32'h2004;
        drive(1, 3'd1, 4'(c), 16'h0040, 32'h2000, pats[p], 0, 0, 0, 0, 0, e);
      end
    end
    for (int c = 11; c <= 15; c++) begin
      e = quiet("R3 reserved code");
      e.pcv = 1; e.npc = 32'h3004;
      drive(1, 3'd1, 4'(c), 16'h0100, 32'h3000, 32'hFFFF_FFFF, 0, 0, 0, 0, 0, e);
    end

    // R4
    e = quiet("R4 jump backward"); e.pcv = 1; e.npc = 32'h4000 - 32'h8;
    drive(1, 3'd2, 0, 16'hFFF8, 32'h4000, 0, 0, 0, 0, 0, 0, e);
    e = quiet("R4 jump forward"); e.pcv = 1; e.npc = 32'h4000 + 32'h7FFC;
    drive(1, 3'd2, 0, 16'h7FFC, 32'h4000, 0, 0, 0, 0, 0, 0, e);

    // R5 register call
    e = quiet("R5 register call");
    e.pcv = 1; e.npc = 32'h8000; e.we = 1; e.addr = 32'h100; e.wd = 32'h5004;
    e.rfw = 1; e.rfi = 4'd13; e.rfd = 32'h104;
    drive(1, 3'd3, 0, 0, 32'h5000, 0, 32'h8000, 32'h100, 4'd13, 0, 0, e);
    // R6 register branch
    e = quiet("R6 register branch");
    e.pcv = 1; e.npc = 32'h9000; e.we = 1; e.addr = 32'h180; e.wd = 32'h6004;
    drive(1, 3'd4, 0, 0, 32'h6000, 0, 32'h9000, 32'h180, 4'd12, 0, 0, e);
    // R7 immediate call
    e = quiet("R7 immediate call");
    e.pcv = 1; e.npc = 32'h7000 + 32'h20; e.we = 1; e.addr = 32'h104; e.wd = 32'h7004;
    e.rfw = 1; e.rfi = 4'd13; e.rfd = 32'h108;
    drive(1, 3'd6, 0, 16'h0020, 32'h7000, 0, 32'h1, 32'h104, 4'd13, 0, 0, e);

    // R11: valid low with op set, op none, stray read data
    idle("R11 valid low");
    drive(0, 3'd3, 0, 0, 32'h5000, 0, 32'h8000, 32'h100, 4'd13, 0, 0, quiet("R11 valid low call"));
    drive(1, 3'd0, 0, 0, 32'h5000, 0, 32'h8000, 32'h100, 4'd13, 0, 0, quiet("R11 op none"));
    drive(0, 3'd0, 0, 0, 0, 0, 0, 0, 0, 1, 32'hDEAD, quiet("R11 stray read data"));

    // R8/R9: return, immediate data
    e = quiet("R8 return request"); e.re = 1; e.addr = 32'h200; e.busy = 1;
    drive(1, 3'd5, 0, 0, 32'hA000, 0, 0, 32'h200, 4'd14, 0, 0, e);
    e = quiet("R9 return completes"); e.pcv = 1; e.npc = 32'hB004;
    e.rfw = 1; e.rfi = 4'd14; e.rfd = 32'h1FC;
    drive(0, 3'd0, 0, 0, 0, 0, 0, 32'h999, 4'd2, 1, 32'hB004, e);
    idle("R9 quiet after return");

    // R8/R9/R10: return with latency, instructions offered while busy
    e = quiet("R8 return request 2"); e.re = 1; e.addr = 32'h300; e.busy = 1;
    drive(1, 3'd5, 0, 0, 32'hA000, 0, 0, 32'h300, 4'd11, 0, 0, e);
    e = quiet("R10 jump ignored while busy"); e.busy = 1;
    drive(1, 3'd2, 0, 16'h0010, 32'hC000, 0, 0, 32'h500, 4'd3, 0, 0, e);
    e = quiet("R10 call ignored while busy"); e.busy = 1;
    drive(1, 3'd3, 0, 0, 32'hC000, 0, 32'hD000, 32'h500, 4'd3, 0, 0, e);
    e = quiet("R10 jump with read data"); e.pcv = 1; e.npc = 32'hE000;
    e.rfw = 1; e.rfi = 4'd11; e.rfd = 32'h2FC;
    drive(1, 3'd2, 0, 16'h0010, 32'hC000, 0, 0, 32'h500, 4'd3, 1, 32'hE000, e);
    idle("R10 quiet after collision");

    repeat (3) @(negedge clk);
    if (!ended) begin
      ended = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule